// File: doc/BRIEF.md
# Software write-protection sequence guard

The guard sits in the write path of a byte-wide nonvolatile memory. Every byte the host writes, as an address and data pair, passes through it. It looks for two key sequences in that stream. The first is a three-byte unlock prefix. The second is a six-byte erase code. From them it keeps a protection flag and decides, for each byte, whether the page-write controller may store that byte in the array.

While protection is off, ordinary bytes are stored. Once a prefix is followed by real data, that data is stored and protection turns on. From then on, a page is accepted only when a fresh prefix comes before it. The unlocked state lasts until the controller signals that the byte-load window has expired. The six-byte code turns protection off again, and none of its bytes reach the array.

The flag stands in for the nonvolatile setting and is clear after reset. The decision for each write appears one cycle after the write, together with an acknowledge.

Top module: `wprot_seq_guard`

## Requirements
- R1: After reset, prot_on is 0 and wr_ack and wr_commit are 0.
- R2: Every accepted write (wr_valid high) gives wr_ack high in the next cycle. While protection is off and no sequence is open, an ordinary byte is committed (wr_commit 1).
- R3: A byte that the matcher consumes as part of a key sequence is never committed. The key bytes are data AA at address 5555, 55 at 2AAA, then A0 at 5555 for the unlock prefix. The erase code is AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555.
- R4: The unlock prefix followed only by window expiry leaves prot_on at 0.
- R5: The first data byte after the unlock prefix is committed, and prot_on reads 1 in the same cycle as that byte's acknowledge.
- R6: After the prefix, further bytes are committed until window_expire. Once the window has expired with protection on, a byte sent without a prefix is discarded.
- R7: With protection on, prefix plus data commits the data and protection stays on.
- R8: The full six-byte erase code clears prot_on at the acknowledge of its last byte. Afterwards, plain bytes commit again.
- R9: A byte that breaks a partial match with protection off is committed, and the matcher returns to idle.
- R10: With protection on, a breaking byte or any unprefixed byte is discarded, and prot_on stays 1.
- R11: A breaking byte that is itself AA@5555 starts a new sequence and is not committed.
- R12: A window expiry in the middle of the erase code aborts it. Later bytes are matched from idle, so prot_on stays 1.
- R13: The erase code sent while unprotected commits nothing and leaves prot_on at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | One host byte write this cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Byte value of the write |
| window_expire | input | 1 | Byte-load window ended; closes any open sequence |
| wr_ack | output | 1 | Decision for the previous write is valid |
| wr_commit | output | 1 | The previous write may be stored in the array |
| prot_on | output | 1 | Software protection active |

## Verification
The stream patterns fall into four groups. The first is plain bytes alone. The second is a lone prefix, a prefix with data, and a prefix with several page bytes. The third is the full erase code, sent both with protection on and with it off. The fourth is sequences broken by a foreign byte, by a repeated lead byte, or by window expiry. Plain bytes on both sides of each protection change show whether the flag really moved. Breaking bytes tried in each protection state separate the store and discard rules for a broken match. The repeated lead byte and the aborted erase code show whether the matcher restarts from idle or keeps stale progress.

// File: rtl/wps_pkg.sv
package wps_pkg;

   // Matcher states: key progress for unlock and erase codes
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_K1   = 3'd1,
      ST_K2   = 3'd2,
      ST_OPEN = 3'd3,
      ST_E3   = 3'd4,
      ST_E4   = 3'd5,
      ST_E5   = 3'd6
   } wps_state_e;

   // Distinct key steps the comparator bank recognises
   localparam int NSTEP    = 5;
   localparam int STP_LEAD = 0;   // lead byte at primary key address
   localparam int STP_SWAP = 1;   // second byte at secondary key address
   localparam int STP_OPEN = 2;   // closes the unlock prefix
   localparam int STP_WIPE = 3;   // turns prefix into erase code
   localparam int STP_OFF  = 4;   // final erase byte

   localparam logic [7:0] KEY_LEAD = 8'hAA;
   localparam logic [7:0] KEY_SWAP = 8'h55;
   localparam logic [7:0] KEY_OPEN = 8'hA0;
   localparam logic [7:0] KEY_WIPE = 8'h80;
   localparam logic [7:0] KEY_OFF  = 8'h20;

   // Per-write action
   typedef struct packed {
      logic cmd;       // consumed as key byte
      logic keep;      // may reach the array
      logic set_prot;
      logic clr_prot;
   } wps_act_t;

endpackage

// File: rtl/wps_key_match.sv
module wps_key_match
   import wps_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] KEY_ADDR_A = 'h5555,
   parameter logic [ADDR_W-1:0] KEY_ADDR_B = 'h2AAA
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic [NSTEP-1:0]  hit
);

   function automatic logic [ADDR_W-1:0] step_addr(input int idx);
      return (idx == STP_SWAP) ? KEY_ADDR_B : KEY_ADDR_A;
   endfunction

   function automatic logic [DATA_W-1:0] step_data(input int idx);
      logic [7:0] b;
      case (idx)
         STP_LEAD: b = KEY_LEAD;
         STP_SWAP: b = KEY_SWAP;
         STP_OPEN: b = KEY_OPEN;
         STP_WIPE: b = KEY_WIPE;
         default:  b = KEY_OFF;
      endcase
      return DATA_W'(b);
   endfunction

   for (genvar i = 0; i < NSTEP; i++) begin : g_step
      localparam logic [ADDR_W-1:0] SA = step_addr(i);
      localparam logic [DATA_W-1:0] SD = step_data(i);
      assign hit[i] = (addr == SA) && (data == SD);
   end

endmodule

// File: rtl/wps_seq_fsm.sv
module wps_seq_fsm
   import wps_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [NSTEP-1:0]  hit,
   input  logic              window_expire,
   input  logic              prot_q,
   output wps_state_e        st_q,
   output wps_act_t          act
);

   wps_state_e base, st_d;

   always_comb begin
      base = window_expire ? ST_IDLE : st_q;
      st_d = base;
      act  = '0;
      if (wr_valid) begin
         // default: treat as byte seen from idle
         if (hit[STP_LEAD]) begin
            st_d    = ST_K1;
            act.cmd = 1'b1;
         end else begin
            st_d     = ST_IDLE;
            act.keep = !prot_q;
         end
         case (base)
            ST_K1: if (hit[STP_SWAP]) begin
               st_d = ST_K2; act.cmd = 1'b1; act.keep = 1'b0;
            end
            ST_K2: if (hit[STP_OPEN]) begin
               st_d = ST_OPEN; act.cmd = 1'b1; act.keep = 1'b0;
            end else if (hit[STP_WIPE]) begin
               st_d = ST_E3; act.cmd = 1'b1; act.keep = 1'b0;
            end
            ST_OPEN: begin
               st_d         = ST_OPEN;
               act.cmd      = 1'b0;
               act.keep     = 1'b1;
               act.set_prot = 1'b1;
            end
            ST_E3: if (hit[STP_LEAD]) begin
               st_d = ST_E4; act.cmd = 1'b1; act.keep = 1'b0;
            end
            ST_E4: if (hit[STP_SWAP]) begin
               st_d = ST_E5; act.cmd = 1'b1; act.keep = 1'b0;
            end
            ST_E5: if (hit[STP_OFF]) begin
               st_d = ST_IDLE; act.cmd = 1'b1; act.keep = 1'b0;
               act.clr_prot = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/wps_commit_stage.sv
module wps_commit_stage
   import wps_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_valid,
   input  wps_act_t act,
   output logic     prot_q,
   output logic     wr_ack,
   output logic     wr_commit
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            prot_q <= 1'b0;
      else if (act.clr_prot) prot_q <= 1'b0;
      else if (act.set_prot) prot_q <= 1'b1;
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_ack    <= 1'b0;
            wr_commit <= 1'b0;
         end else begin
            wr_ack    <= wr_valid;
            wr_commit <= wr_valid && act.keep;
         end
      end
   end else begin : g_comb
      assign wr_ack    = wr_valid;
      assign wr_commit = wr_valid && act.keep;
   end

endmodule

// File: rtl/wprot_seq_guard.sv
module wprot_seq_guard
   import wps_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] KEY_ADDR_A = 'h5555,
   parameter logic [ADDR_W-1:0] KEY_ADDR_B = 'h2AAA,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              window_expire,
   output logic              wr_ack,
   output logic              wr_commit,
   output logic              prot_on
);

   if (DATA_W < 8) begin : g_bad_data
      $error("wprot_seq_guard: DATA_W must hold an 8-bit key byte");
   end
   if (KEY_ADDR_A == KEY_ADDR_B) begin : g_bad_keys
      $error("wprot_seq_guard: key addresses must differ");
   end

   logic [NSTEP-1:0] hit;
   wps_state_e       st_q;
   wps_act_t         act;
   logic             prot_q;

   wps_key_match #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B)
   ) u_match (
      .addr(wr_addr), .data(wr_data), .hit(hit)
   );

   wps_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .hit(hit),
      .window_expire(window_expire), .prot_q(prot_q),
      .st_q(st_q), .act(act)
   );

   wps_commit_stage #(.OUT_REG(OUT_REG)) u_commit (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .act(act),
      .prot_q(prot_q), .wr_ack(wr_ack), .wr_commit(wr_commit)
   );

   assign prot_on = prot_q;

endmodule

// File: rtl/wps_seq_guard_chk.sv
module wps_seq_guard_chk
   import wps_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] KEY_ADDR_A = 'h5555,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              window_expire,
   input logic              wr_ack,
   input logic              wr_commit,
   input logic              prot_on,
   input wps_state_e        st_q
);

   logic lead_byte;
   assign lead_byte = wr_valid && (wr_addr == KEY_ADDR_A) &&
                      (wr_data == DATA_W'(KEY_LEAD));

   if (OUT_REG) begin : g_seq
      p_ack_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
         wr_valid |=> wr_ack);

      p_lead_not_stored_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (lead_byte && st_q != ST_OPEN && !window_expire) |=> !wr_commit);

      p_prot_rise_stores_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(prot_on) |-> (wr_ack && wr_commit));

      p_prot_fall_on_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(prot_on) |-> (wr_ack && !wr_commit));

      p_locked_idle_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (prot_on && wr_valid && (st_q == ST_IDLE || window_expire)) |=> !wr_commit);
   end

   p_commit_needs_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> wr_ack);

   p_expire_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (window_expire && !wr_valid) |=> (st_q == ST_IDLE));

endmodule

bind wprot_seq_guard wps_seq_guard_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR_A(KEY_ADDR_A), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
   .wr_data(wr_data), .window_expire(window_expire), .wr_ack(wr_ack),
   .wr_commit(wr_commit), .prot_on(prot_on), .st_q(st_q)
);

// File: tb/wprot_seq_guard_test.sv
module wprot_seq_guard_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 15;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          window_expire = 1'b0;
   logic          wr_ack, wr_commit, prot_on;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wprot_seq_guard uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .window_expire(window_expire), .wr_ack(wr_ack),
      .wr_commit(wr_commit), .prot_on(prot_on)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // one write; decision and flag sampled at the next falling edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic exp_c, input string tag);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
      check({tag, " ack"}, wr_ack, 1'b1);
      check({tag, " commit"}, wr_commit, exp_c);
   endtask

   task automatic expire();
      @(negedge clk);
      window_expire = 1'b1;
      @(negedge clk);
      window_expire = 1'b0;
   endtask

   task automatic prefix(input string tag);
      wr(15'h5555, 8'hAA, 1'b0, tag);
      wr(15'h2AAA, 8'h55, 1'b0, tag);
      wr(15'h5555, 8'hA0, 1'b0, tag);
   endtask

   task automatic erase_code(input string tag);
      wr(15'h5555, 8'hAA, 1'b0, tag);
      wr(15'h2AAA, 8'h55, 1'b0, tag);
      wr(15'h5555, 8'h80, 1'b0, tag);
      wr(15'h5555, 8'hAA, 1'b0, tag);
      wr(15'h2AAA, 8'h55, 1'b0, tag);
      wr(15'h5555, 8'h20, 1'b0, tag);
   endtask

   task automatic t_reset();
      check("R1 prot", prot_on, 1'b0);
      check("R1 ack", wr_ack, 1'b0);
      check("R1 commit", wr_commit, 1'b0);
   endtask

   task automatic t_plain();
      wr(15'h0123, 8'h5A, 1'b1, "R2 plain");
      wr(15'h2AAA, 8'h55, 1'b1, "R2 swap byte from idle");
      @(negedge clk);
      check("R2 ack drops", wr_ack, 1'b0);
   endtask

   task automatic t_prefix_only();
      prefix("R3 prefix");
      expire();
      check("R4 prot after bare prefix", prot_on, 1'b0);
      wr(15'h0010, 8'h11, 1'b1, "R4 plain after bare prefix");
   endtask

   task automatic t_enable();
      prefix("R3 enable prefix");
      wr(15'h0040, 8'h77, 1'b1, "R5 first data");
      check("R5 prot set", prot_on, 1'b1);
      wr(15'h0041, 8'h78, 1'b1, "R6 page byte");
      expire();
      wr(15'h0042, 8'h79, 1'b0, "R6 after expiry");
   endtask

   task automatic t_prot_write();
      prefix("R7 prefix");
      wr(15'h0080, 8'h01, 1'b1, "R7 data");
      check("R7 prot kept", prot_on, 1'b1);
      expire();
   endtask

   task automatic t_break_prot();
      wr(15'h5555, 8'hAA, 1'b0, "R10 lead");
      wr(15'h0300, 8'h12, 1'b0, "R10 breaker");
      wr(15'h2AAA, 8'h55, 1'b0, "R10 idle swap");
      check("R10 prot", prot_on, 1'b1);
   endtask

   task automatic t_restart();
      wr(15'h5555, 8'hAA, 1'b0, "R11 lead");
      wr(15'h5555, 8'hAA, 1'b0, "R11 repeat lead");
      wr(15'h2AAA, 8'h55, 1'b0, "R11 swap");
      wr(15'h5555, 8'hA0, 1'b0, "R11 open");
      wr(15'h0090, 8'h44, 1'b1, "R11 data");
      expire();
   endtask

   task automatic t_abort_erase();
      wr(15'h5555, 8'hAA, 1'b0, "R12 lead");
      wr(15'h2AAA, 8'h55, 1'b0, "R12 swap");
      wr(15'h5555, 8'h80, 1'b0, "R12 wipe");
      expire();
      wr(15'h5555, 8'hAA, 1'b0, "R12 lead again");
      wr(15'h2AAA, 8'h55, 1'b0, "R12 swap again");
      wr(15'h5555, 8'h20, 1'b0, "R12 stray off");
      check("R12 prot kept", prot_on, 1'b1);
   endtask

   task automatic t_erase();
      erase_code("R8 erase");
      check("R8 prot cleared", prot_on, 1'b0);
      wr(15'h0100, 8'h66, 1'b1, "R8 plain after erase");
   endtask

   task automatic t_break_unprot();
      wr(15'h5555, 8'hAA, 1'b0, "R9 lead");
      wr(15'h0222, 8'h33, 1'b1, "R9 breaker");
      wr(15'h2AAA, 8'h55, 1'b1, "R9 idle swap");
   endtask

   task automatic t_erase_unprot();
      erase_code("R13 erase");
      check("R13 prot", prot_on, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_plain();
      t_prefix_only();
      t_enable();
      t_prot_write();
      t_break_prot();
      t_restart();
      t_abort_erase();
      t_erase();
      t_break_unprot();
      t_erase_unprot();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule